// File: doc/BRIEF.md
# Core Time Base Tick Generator

This block produces the increment enables and the 64-bit time base values for a group of processor cores. Each core picks, through its own select bit, one of two tick sources: the platform clock divided by a fixed factor of 16, or an external real-time clock pin that is asynchronous to the platform clock. The chosen tick stream always passes through a second divider. That divider's ratio is set by a 2-bit code shared by all cores, and it cannot be bypassed. With the platform source, the highest possible tick rate is therefore one tick every 128 platform cycles.

All division is carried out with one-cycle enable pulses in the platform clock domain, so the block creates no derived clocks. The external pin passes through a two-flop synchronizer, and each of its rising edges becomes one source tick. The divider code is a static configuration input and is expected to hold steady once reset is released. When a core's select bit changes, that core's second-stage count restarts. The first tick after a switch therefore always spans a full ratio of ticks from the new source.

Top module: `tbtick_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it is sampled high, every `tick_en` bit is 0 and every time base value is 0.
- R2: On the platform path, successive ticks of a core are exactly 16 × ratio platform cycles apart, and no tick ever follows the previous one (or reset) by fewer than 8 cycles.
- R3: The divider code `div_code` sets the ratio as follows: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 24 and 2'b11 gives 32, for both sources.
- R4: On the external clock path, each tick of a core corresponds to exactly ratio rising edges of `rtc_in`, provided `rtc_in` runs below half the platform clock rate.
- R5: Bit i of `src_sel` picks the source of core i (0 = platform/16, 1 = external clock), independently of the other cores.
- R6: Each `tick_en` bit is a single-cycle pulse and is never high in two consecutive cycles.
- R7: A core's time base rises by exactly one in the cycle after each of its `tick_en` pulses and holds its value in every other cycle.
- R8: When a core's select bit changes, that core's divider count restarts from zero. The first tick after the change follows a full ratio of ticks from the new source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Platform clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_in | input | 1 | External real-time clock pin, asynchronous |
| src_sel | input | NUM_CORES | Per-core source select, 1 = external clock |
| div_code | input | 2 | Static second-stage ratio code |
| tick_en | output | NUM_CORES | Per-core time base increment enable |
| tb_value | output | NUM_CORES*TB_W | Per-core time base, core i in bits [i*TB_W +: TB_W] |

## Verification
The assertions check the single-cycle shape of every tick pulse, the exact step-by-one and hold behaviour of each time base, the quiet state that reset forces, and a lower bound on the spacing between ticks on every cycle. They cannot show the exact tick spacing for each divider code. They also cannot show the edge count on the external clock path or the restart after a source switch. The bench's scenarios measure these spacings against platform cycles and against the rising edges it drives onto the pin.

// File: rtl/tbtick_pkg.sv
package tbtick_pkg;
  localparam int CODE_W  = 2;
  localparam int RATIO_W = 6;
  localparam int RATIO_STEP = 8;

  // Code n selects a ratio of (n + 1) * 8.
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
    return RATIO_W'({1'b0, code, 3'b000}) + RATIO_W'(RATIO_STEP);
  endfunction
endpackage

// File: rtl/tbtick_prescaler.sv
module tbtick_prescaler #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == PS_LAST);
      if (cnt_q == PS_LAST) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tbtick_rtc_sync.sv
module tbtick_rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rtc_async,
  output logic tick_o
);
  // Flops [0..STAGES-1] synchronize the pin; flop [STAGES] holds its previous value.
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      shift_q <= {shift_q[STAGES-1:0], rtc_async};
      tick_o  <= shift_q[STAGES-1] & ~shift_q[STAGES];
    end
  end
endmodule

// File: rtl/tbtick_core_div.sv
module tbtick_core_div
  import tbtick_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_rtc,
  input  logic               plat_tick,
  input  logic               rtc_tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick_o
);
  logic               sel_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               src_tick;
  logic               sel_changed;

  always_comb begin
    src_tick    = sel_rtc ? rtc_tick : plat_tick;
    sel_changed = (sel_rtc != sel_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= sel_rtc;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      sel_q  <= sel_rtc;
      tick_o <= 1'b0;
      if (sel_changed) begin
        cnt_q <= '0;
      end else if (src_tick) begin
        if (cnt_q == ratio - RATIO_W'(1)) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + RATIO_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tbtick_tb_counter.sv
module tbtick_tb_counter #(
  parameter int TB_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  output logic [TB_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (inc) value <= value + {{(TB_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/tbtick_gen.sv
module tbtick_gen
  import tbtick_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int TB_W        = 64,
  parameter int PRESCALE    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rtc_in,
  input  logic [NUM_CORES-1:0]      src_sel,
  input  logic [CODE_W-1:0]         div_code,
  output logic [NUM_CORES-1:0]      tick_en,
  output logic [NUM_CORES*TB_W-1:0] tb_value
);
  logic               plat_tick;
  logic               rtc_tick;
  logic [RATIO_W-1:0] ratio_q;

  always_ff @(posedge clk) begin
    ratio_q <= ratio_of(div_code);
  end

  tbtick_prescaler #(.PRESCALE(PRESCALE)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .tick_o (plat_tick)
  );

  tbtick_rtc_sync #(.STAGES(SYNC_STAGES)) u_rtc_sync (
    .clk       (clk),
    .rst       (rst),
    .rtc_async (rtc_in),
    .tick_o    (rtc_tick)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    tbtick_core_div u_div (
      .clk       (clk),
      .rst       (rst),
      .sel_rtc   (src_sel[c]),
      .plat_tick (plat_tick),
      .rtc_tick  (rtc_tick),
      .ratio     (ratio_q),
      .tick_o    (tick_en[c])
    );

    tbtick_tb_counter #(.TB_W(TB_W)) u_tb (
      .clk   (clk),
      .rst   (rst),
      .inc   (tick_en[c]),
      .value (tb_value[c*TB_W +: TB_W])
    );
  end
endmodule

// File: rtl/tbtick_gen_chk.sv
module tbtick_gen_chk #(
  parameter int NUM_CORES = 4,
  parameter int TB_W      = 64
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CORES-1:0]      tick_en,
  input logic [NUM_CORES*TB_W-1:0] tb_value
);
  localparam int GAP_W   = 8;
  localparam int MIN_GAP = 8;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (tick_en == '0 && tb_value == '0)); // R1

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
      if (rst || tick_en[c])        gap_q <= '0;
      else if (gap_q != '1)         gap_q <= gap_q + 1'b1;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      tick_en[c] |=> !tick_en[c]); // R6

    AST_TB_STEP: assert property (@(posedge clk) disable iff (rst)
      tick_en[c] |=> (tb_value[c*TB_W +: TB_W] == $past(tb_value[c*TB_W +: TB_W]) + 1'b1)); // R7

    AST_TB_HOLD: assert property (@(posedge clk) disable iff (rst)
      !tick_en[c] |=> $stable(tb_value[c*TB_W +: TB_W])); // R7

    AST_MIN_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
      tick_en[c] |-> (gap_q >= GAP_W'(MIN_GAP))); // R2
  end
endmodule

bind tbtick_gen tbtick_gen_chk #(.NUM_CORES(NUM_CORES), .TB_W(TB_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .tb_value (tb_value)
);

// File: tb/tb_tbtick_gen.sv
`timescale 1ns/1ps
module tb_tbtick_gen;
  localparam int NC   = 4;
  localparam int TBW  = 64;
  localparam int HALF = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rtc_in = 1'b0;
  logic [NC-1:0]   src_sel = '0;
  logic [1:0]      div_code = 2'b00;
  logic [NC-1:0]   tick_en;
  logic [NC*TBW-1:0] tb_value;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int rtc_edges = 0;
  int rtc_ph = 0;
  bit rtc_run = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tbtick_gen #(.NUM_CORES(NC), .TB_W(TBW)) dut (
    .clk(clk), .rst(rst), .rtc_in(rtc_in), .src_sel(src_sel),
    .div_code(div_code), .tick_en(tick_en), .tb_value(tb_value)
  );

  // External clock: 2*HALF platform cycles per period, well below clk/2.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rtc_run) begin
        rtc_ph++;
        if (rtc_ph >= HALF) begin
          rtc_ph = 0;
          rtc_in = ~rtc_in;
          if (rtc_in) rtc_edges++;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_range(input string req, input string what, input longint act,
                             input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic longint tb_of(input int c);
    return longint'(tb_value[c*TBW +: TBW]);
  endfunction

  task automatic do_reset(input logic [1:0] code, input logic [NC-1:0] sel);
    rst = 1'b1;
    div_code = code;
    src_sel = sel;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_tick(input int c, output int at);
    int n;
    n = 0;
    at = -1;
    while (n < 6000) begin
      @(negedge clk);
      if (tick_en[c]) begin
        at = cyc;
        break;
      end
      n++;
    end
    if (at < 0) begin
      fails++;
      $display("FAIL timeout waiting for tick on core %0d: actual none expected pulse", c);
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "tick_en in reset", longint'(tick_en), 0);
    check("R1", "time base in reset", longint'(tb_of(0) | tb_of(NC-1)), 0);
  endtask

  task automatic test_platform(input logic [1:0] code);
    int t0, t1, t2, exp;
    exp = 16 * 8 * (int'(code) + 1);
    rtc_run = 1'b0;
    do_reset(code, '0);
    wait_tick(0, t0);
    wait_tick(0, t1);
    wait_tick(0, t2);
    check("R2", $sformatf("platform spacing code %0d", code), t2 - t1, exp);
    check("R3", $sformatf("platform spacing repeat code %0d", code), t1 - t0, exp);
    @(negedge clk);
    check("R7", "time base after three ticks", tb_of(0), 3);
  endtask

  task automatic test_rtc(input logic [1:0] code);
    int t, e0, e1;
    rtc_run = 1'b1;
    do_reset(code, '1);
    wait_tick(NC-1, t);
    e0 = rtc_edges;
    wait_tick(NC-1, t);
    e1 = rtc_edges;
    check("R4", $sformatf("rtc edges per tick code %0d", code), e1 - e0, 8 * (int'(code) + 1));
    @(negedge clk);
    check("R7", "time base after two rtc ticks", tb_of(NC-1), 2);
  endtask

  task automatic test_mixed();
    int t0, t1, e0, e1;
    rtc_run = 1'b1;
    do_reset(2'b01, 4'b0010);
    wait_tick(0, t0);
    wait_tick(0, t1);
    check("R5", "core0 platform spacing beside rtc core", t1 - t0, 256);
    wait_tick(1, t0);
    e0 = rtc_edges;
    wait_tick(1, t1);
    e1 = rtc_edges;
    check("R5", "core1 rtc edges per tick", e1 - e0, 16);
    wait_tick(2, t0);
    wait_tick(2, t1);
    check("R5", "core2 platform spacing", t1 - t0, 256);
  endtask

  task automatic test_switch();
    int t, t0, e0, e1, target;
    rtc_run = 1'b1;
    do_reset(2'b00, 4'b0001);
    wait_tick(0, t);
    target = rtc_edges + 5;
    while (rtc_edges < target) @(negedge clk);
    repeat (8) @(negedge clk);
    rtc_run = 1'b0;
    repeat (4) @(negedge clk);
    src_sel[0] = 1'b0;
    t0 = cyc;
    wait_tick(0, t);
    check_range("R8", "cycles to first platform tick after switch", t - t0, 113, 132);
    repeat (40) @(negedge clk);
    src_sel[0] = 1'b1;
    e0 = rtc_edges;
    rtc_run = 1'b1;
    wait_tick(0, t);
    e1 = rtc_edges;
    check("R8", "rtc edges to first tick after switch back", e1 - e0, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    for (int k = 0; k < 4; k++) test_platform(2'(k));
    for (int k = 0; k < 4; k++) test_rtc(2'(k));
    test_mixed();
    test_switch();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule